// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block sits on the host side of an asynchronous 1K-refresh DRAM and takes sole charge of keeping the array alive. Once reset is released it holds off for a long power-up pause. It then borrows the bus and issues a burst of CAS-before-RAS cycles to initialise the device. After that it raises `ready_o` and schedules one CAS-before-RAS refresh per interval, so that the device's internal row counter visits every row within the retention period. Because the device generates the refresh row address itself, the block keeps no row counter and never drives the address bus.

A refresh that falls due is queued, not issued at once. It waits until the access controller reports idle, and the queue saturates at a parameterised depth. When the queue is full the block raises `urgent_o` and requests the bus without waiting for idle. Once it is granted, every queued refresh is issued back to back with only the minimum precharge between them. On request the block can also park the device in self-refresh: a CAS-before-RAS entry held low for the self-refresh hold time, then kept low for as long as the request stays high. A separate pulse input re-runs the initialisation burst, for use after the clock has been stopped for a long time. All timings are whole clock-cycle counts set by parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset `ras_n_o`, `lcas_n_o` and `ucas_n_o` are high and `ready_o` and `bus_req_o` are low. No strobe falls during the first PWRUP_CYC cycles after reset is released.
- R2: After the power-up pause, exactly INIT_CYC CAS-before-RAS cycles are issued, and then `ready_o` goes high.
- R3: Each CAS-before-RAS refresh drives both CAS strobes low for CSR_CYC cycles while RAS is high, then drives RAS low for RAS_CYC cycles. CAS stays low for the first CHR_CYC of those cycles. RAS never falls unless CAS is already low.
- R4: Between two strobe cycles RAS stays high for at least RP_CYC cycles. Queued refreshes issued under one grant are separated by exactly RP_CYC cycles of precharge.
- R5: Once `ready_o` is high, one refresh falls due every REF_INTERVAL cycles. With the controller idle and the bus granted, each due refresh is issued.
- R6: While `ctrl_idle_i` is low and fewer than MAX_PEND refreshes are queued, `bus_req_o` and `urgent_o` stay low.
- R7: When MAX_PEND refreshes are queued, `urgent_o` goes high and `bus_req_o` is asserted regardless of `ctrl_idle_i`. Once granted, all queued refreshes are issued back to back and `urgent_o` drops.
- R8: RAS or CAS is driven low only while `bus_req_o` is high.
- R9: With `sr_req_i` high and `ready_o` high, the block enters self-refresh through a CAS-before-RAS entry. RAS and CAS are then held low, and `sr_active_o` rises after at least SR_HOLD_CYC cycles of RAS low. RAS remains low while the request stays high.
- R10: When `sr_req_i` falls, RAS returns high and `sr_active_o` falls. No new strobe cycle starts until RAS has been high for at least RPS_CYC cycles.
- R11: A pulse on `reinit_i` drops `ready_o`, issues INIT_CYC CAS-before-RAS cycles again, and then raises `ready_o`.
- R12: `lcas_n_o` and `ucas_n_o` carry identical values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_idle_i | input | 1 | Access controller has no transfer in progress |
| bus_gnt_i | input | 1 | Access controller hands the DRAM strobes to this block |
| sr_req_i | input | 1 | Level request to hold the device in self-refresh |
| reinit_i | input | 1 | Pulse: repeat the initialisation burst |
| bus_req_o | output | 1 | Requests, then holds, ownership of the strobes |
| urgent_o | output | 1 | Refresh queue full; controller should yield |
| ready_o | output | 1 | Initialisation complete; normal access allowed |
| sr_active_o | output | 1 | Device is held in self-refresh |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |

## Verification
The assertions assume that the access controller grants the bus only while a request is pending and keeps granting it until the request drops. They also assume that `reinit_i` is a single-cycle pulse. The bench meets both conditions by deriving the grant as a gated copy of `bus_req_o`, and it closes the gate only at quiet points to hold refreshes back. `sr_req_i` is raised only after `ready_o` is high and the refresh queue is empty. It is released only once `sr_active_o` is high, so the entry hold always runs to completion.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_WAIT,
        ST_CSR,
        ST_RAS_CAS,
        ST_RAS_ONLY,
        ST_PRE,
        ST_SR_HOLD,
        ST_SR_ACT,
        ST_SR_EXIT
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_INIT,
        OP_REF,
        OP_SR
    } seq_op_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int unsigned REF_INTERVAL = 3000,
    parameter int unsigned MAX_PEND     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic dec_i,
    output logic pend_nz_o,
    output logic pend_full_o
);

    localparam int unsigned CW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam int unsigned PW = $clog2(MAX_PEND + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(REF_INTERVAL - 1);
    localparam logic [PW-1:0] PEND_MAX = PW'(MAX_PEND);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [PW-1:0] pend;
    } sched_t;

    sched_t s_d, s_q;
    logic   tick;

    always_comb begin
        s_d  = s_q;
        tick = en_i && (s_q.cnt == CNT_LAST);
        if (clr_i) begin
            s_d.cnt  = '0;
            s_d.pend = '0;
        end else begin
            if (tick) begin
                s_d.cnt = '0;
            end else if (en_i) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (tick && !dec_i) begin
                if (s_q.pend != PEND_MAX) begin
                    s_d.pend = s_q.pend + 1'b1;
                end
            end else if (dec_i && !tick) begin
                if (s_q.pend != '0) begin
                    s_d.pend = s_q.pend - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_nz_o   = (s_q.pend != '0);
    assign pend_full_o = (s_q.pend == PEND_MAX);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_seq_pkg::*;
#(
    parameter int unsigned PWRUP_CYC    = 40000,
    parameter int unsigned INIT_CYC     = 8,
    parameter int unsigned REF_INTERVAL = 3000,
    parameter int unsigned MAX_PEND     = 4,
    parameter int unsigned CSR_CYC      = 1,
    parameter int unsigned CHR_CYC      = 3,
    parameter int unsigned RAS_CYC      = 16,
    parameter int unsigned RP_CYC       = 27,
    parameter int unsigned SR_HOLD_CYC  = 20100,
    parameter int unsigned RPS_CYC      = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_idle_i,
    input  logic bus_gnt_i,
    input  logic sr_req_i,
    input  logic reinit_i,
    output logic bus_req_o,
    output logic urgent_o,
    output logic ready_o,
    output logic sr_active_o,
    output logic ras_n_o,
    output logic lcas_n_o,
    output logic ucas_n_o
);

    localparam int unsigned LONGEST = max_u(max_u(PWRUP_CYC, SR_HOLD_CYC),
                                            max_u(max_u(RAS_CYC, RP_CYC), max_u(CSR_CYC, RPS_CYC)));
    localparam int unsigned TW = $clog2(LONGEST + 1);
    localparam int unsigned IW = $clog2(INIT_CYC + 1);

    localparam logic [TW-1:0] T_CSR  = TW'(CSR_CYC - 1);
    localparam logic [TW-1:0] T_CHR  = TW'(CHR_CYC - 1);
    localparam logic [TW-1:0] T_RAS  = TW'(RAS_CYC - CHR_CYC - 1);
    localparam logic [TW-1:0] T_RP   = TW'(RP_CYC - 1);
    localparam logic [TW-1:0] T_HOLD = TW'(SR_HOLD_CYC - 1);
    localparam logic [TW-1:0] T_RPS  = TW'(RPS_CYC - 1);
    localparam logic [IW-1:0] INIT_LD = IW'(INIT_CYC);

    typedef struct packed {
        seq_state_e    st;
        seq_op_e       op;
        logic [IW-1:0] init_left;
        logic          ready;
        logic          reinit_pend;
    } seq_regs_t;

    seq_regs_t       r_d, r_q;
    logic            t_load, t_done;
    logic [TW-1:0]   t_val;
    logic            ref_dec, pend_nz, pend_full;
    logic            sched_en, sched_clr;
    logic            go_init, go_sr, go_ref, have_work;
    logic            in_sr;

    seq_phase_timer #(
        .W       (TW),
        .RST_VAL (PWRUP_CYC - 1)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .done_o (t_done)
    );

    assign in_sr     = (r_q.st == ST_SR_HOLD) || (r_q.st == ST_SR_ACT) || (r_q.st == ST_SR_EXIT);
    assign sched_en  = r_q.ready && !in_sr;
    assign sched_clr = in_sr;

    refresh_scheduler #(
        .REF_INTERVAL (REF_INTERVAL),
        .MAX_PEND     (MAX_PEND)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (sched_en),
        .clr_i       (sched_clr),
        .dec_i       (ref_dec),
        .pend_nz_o   (pend_nz),
        .pend_full_o (pend_full)
    );

    assign go_init   = (r_q.init_left != '0);
    assign go_sr     = !go_init && r_q.ready && sr_req_i;
    assign go_ref    = !go_init && !go_sr && pend_nz;
    assign have_work = go_init || go_sr || go_ref;

    always_comb begin
        r_d             = r_q;
        r_d.reinit_pend = r_q.reinit_pend | reinit_i;
        t_load          = 1'b0;
        t_val           = '0;
        ref_dec         = 1'b0;

        case (r_q.st)
            ST_PWRUP: begin
                if (t_done) begin
                    r_d.st = ST_WAIT;
                end
            end

            ST_IDLE: begin
                if (r_q.reinit_pend || reinit_i) begin
                    r_d.reinit_pend = 1'b0;
                    r_d.ready       = 1'b0;
                    r_d.init_left   = INIT_LD;
                    r_d.st          = ST_WAIT;
                end else if (r_q.ready && (sr_req_i || (pend_nz && (ctrl_idle_i || pend_full)))) begin
                    r_d.st = ST_WAIT;
                end
            end

            ST_WAIT: begin
                if (bus_gnt_i) begin
                    if (have_work) begin
                        r_d.st = ST_CSR;
                        t_load = 1'b1;
                        t_val  = T_CSR;
                        if (go_init) begin
                            r_d.op        = OP_INIT;
                            r_d.init_left = r_q.init_left - 1'b1;
                        end else if (go_sr) begin
                            r_d.op = OP_SR;
                        end else begin
                            r_d.op  = OP_REF;
                            ref_dec = 1'b1;
                        end
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end

            ST_CSR: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (r_q.op == OP_SR) begin
                        r_d.st = ST_SR_HOLD;
                        t_val  = T_HOLD;
                    end else begin
                        r_d.st = ST_RAS_CAS;
                        t_val  = T_CHR;
                    end
                end
            end

            ST_RAS_CAS: begin
                if (t_done) begin
                    r_d.st = ST_RAS_ONLY;
                    t_load = 1'b1;
                    t_val  = T_RAS;
                end
            end

            ST_RAS_ONLY: begin
                if (t_done) begin
                    r_d.st = ST_PRE;
                    t_load = 1'b1;
                    t_val  = T_RP;
                end
            end

            ST_PRE: begin
                if (t_done) begin
                    if (r_q.op == OP_INIT && r_q.init_left == '0) begin
                        r_d.ready = 1'b1;
                    end
                    if (bus_gnt_i && have_work && !r_q.reinit_pend && !go_sr) begin
                        r_d.st = ST_CSR;
                        t_load = 1'b1;
                        t_val  = T_CSR;
                        if (go_init) begin
                            r_d.op        = OP_INIT;
                            r_d.init_left = r_q.init_left - 1'b1;
                        end else begin
                            r_d.op  = OP_REF;
                            ref_dec = 1'b1;
                        end
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end

            ST_SR_HOLD: begin
                if (t_done) begin
                    r_d.st = ST_SR_ACT;
                end
            end

            ST_SR_ACT: begin
                if (!sr_req_i) begin
                    r_d.st = ST_SR_EXIT;
                    t_load = 1'b1;
                    t_val  = T_RPS;
                end
            end

            ST_SR_EXIT: begin
                if (t_done) begin
                    r_d.st = ST_IDLE;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st          <= ST_PWRUP;
            r_q.op          <= OP_INIT;
            r_q.init_left   <= INIT_LD;
            r_q.ready       <= 1'b0;
            r_q.reinit_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    logic cas_low, ras_low;

    always_comb begin
        cas_low = (r_q.st == ST_CSR) || (r_q.st == ST_RAS_CAS) ||
                  (r_q.st == ST_SR_HOLD) || (r_q.st == ST_SR_ACT);
        ras_low = (r_q.st == ST_RAS_CAS) || (r_q.st == ST_RAS_ONLY) ||
                  (r_q.st == ST_SR_HOLD) || (r_q.st == ST_SR_ACT);
    end

    assign ras_n_o     = !ras_low;
    assign lcas_n_o    = !cas_low;
    assign ucas_n_o    = !cas_low;
    assign bus_req_o   = (r_q.st != ST_PWRUP) && (r_q.st != ST_IDLE);
    assign urgent_o    = pend_full;
    assign ready_o     = r_q.ready;
    assign sr_active_o = (r_q.st == ST_SR_ACT);

endmodule

// File: rtl/refresh_seq_checker.sv
module refresh_seq_checker #(
    parameter int unsigned RP_CYC  = 27,
    parameter int unsigned RPS_CYC = 27
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic bus_req,
    input logic urgent,
    input logic sr_active
);

    logic [15:0] hi_cnt_q;
    logic        sr_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q  <= '1;
            sr_seen_q <= 1'b0;
        end else begin
            if (!ras_n) begin
                hi_cnt_q <= '0;
            end else if (hi_cnt_q != '1) begin
                hi_cnt_q <= hi_cnt_q + 1'b1;
            end
            if (sr_active) begin
                sr_seen_q <= 1'b1;
            end else if (!ras_n) begin
                sr_seen_q <= 1'b0;
            end
        end
    end

    p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!lcas_n && !ucas_n && $past(!lcas_n)));

    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt_q >= 16'(RP_CYC)));

    p_urgent_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && !bus_req) |=> bus_req);

    p_strobe_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !lcas_n || !ucas_n) |-> bus_req);

    p_sr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ras_n && !lcas_n));

    p_sr_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && sr_seen_q) |-> (hi_cnt_q >= 16'(RPS_CYC)));

    p_sr_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> ras_n);

endmodule

bind dram_refresh_seq refresh_seq_checker #(
    .RP_CYC  (RP_CYC),
    .RPS_CYC (RPS_CYC)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n_o),
    .lcas_n    (lcas_n_o),
    .ucas_n    (ucas_n_o),
    .bus_req   (bus_req_o),
    .urgent    (urgent_o),
    .sr_active (sr_active_o)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

    localparam int PWRUP  = 50;
    localparam int NINIT  = 8;
    localparam int IVL    = 200;
    localparam int MAXP   = 4;
    localparam int CSR    = 2;
    localparam int CHR    = 3;
    localparam int RASC   = 10;
    localparam int RP     = 6;
    localparam int SRH    = 40;
    localparam int RPS    = 7;
    localparam int K_CBR  = 1;
    localparam int K_SR   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_idle = 1'b1;
    logic gnt_en = 1'b1;
    logic sr_req = 1'b0;
    logic reinit = 1'b0;
    logic bus_gnt;
    logic bus_req, urgent, ready, sr_active, ras_n, lcas_n, ucas_n;

    always #2.5 clk = ~clk;

    assign bus_gnt = gnt_en & bus_req;

    dram_refresh_seq #(
        .PWRUP_CYC (PWRUP), .INIT_CYC (NINIT), .REF_INTERVAL (IVL), .MAX_PEND (MAXP),
        .CSR_CYC (CSR), .CHR_CYC (CHR), .RAS_CYC (RASC), .RP_CYC (RP),
        .SR_HOLD_CYC (SRH), .RPS_CYC (RPS)
    ) dut (
        .clk (clk), .rst_n (rst_n), .ctrl_idle_i (ctrl_idle), .bus_gnt_i (bus_gnt),
        .sr_req_i (sr_req), .reinit_i (reinit), .bus_req_o (bus_req), .urgent_o (urgent),
        .ready_o (ready), .sr_active_o (sr_active), .ras_n_o (ras_n),
        .lcas_n_o (lcas_n), .ucas_n_o (ucas_n)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_expect(input int kind, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(kind);
    endtask

    // monitor / scoreboard
    int ph = 0, csr_c = 0, ras_c = 0, chr_c = 0, gap_c = 0, last_kind = 0;
    int n_cbr = 0, n_sr = 0, b2b = 0, first_cas = -1, cyc = 0, mism = 0;

    task automatic finish_event();
        int kind;
        int exp;
        kind = (chr_c == ras_c && ras_c >= SRH) ? K_SR : K_CBR;
        if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected strobe cycle", kind, 0);
        end else begin
            exp = exp_q.pop_front();
            check(kind == exp, "R3 cycle kind", kind, exp);
        end
        if (kind == K_CBR) begin
            check(csr_c == CSR, "R3 CAS lead", csr_c, CSR);
            check(ras_c == RASC, "R3 RAS width", ras_c, RASC);
            check(chr_c == CHR, "R3 CAS hold", chr_c, CHR);
            n_cbr++;
        end else begin
            check(csr_c == CSR, "R9 entry CAS lead", csr_c, CSR);
            check(ras_c >= SRH + 1, "R9 self-refresh RAS low", ras_c, SRH + 1);
            n_sr++;
        end
        last_kind = kind;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0; gap_c = 0; cyc = 0;
        end else begin
            cyc++;
            if (lcas_n != ucas_n) mism++;
            case (ph)
                0: begin
                    if (!ras_n) begin
                        check(1'b0, "R3 RAS fell without CAS", 0, 1);
                        ph = 2; ras_c = 1; chr_c = 0; csr_c = 0;
                    end else if (!lcas_n) begin
                        ph = 1; csr_c = 1;
                        if (first_cas < 0) first_cas = cyc;
                        if (last_kind == K_SR) check(gap_c >= RPS, "R10 recovery", gap_c, RPS);
                        else if (last_kind == K_CBR) check(gap_c >= RP, "R4 precharge", gap_c, RP);
                        if (last_kind == K_CBR && gap_c == RP) b2b++;
                    end else begin
                        gap_c++;
                    end
                end
                1: begin
                    if (!ras_n) begin
                        ph = 2; ras_c = 1; chr_c = lcas_n ? 0 : 1;
                    end else begin
                        csr_c++;
                    end
                end
                default: begin
                    if (!ras_n) begin
                        ras_c++;
                        if (!lcas_n) chr_c++;
                    end else begin
                        finish_event();
                        ph = 0; gap_c = 1;
                    end
                end
            endcase
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (30000) @(negedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        push_expect(K_CBR, NINIT);
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(10);
        // R1 reset state
        check(ras_n && lcas_n && ucas_n, "R1 strobes idle", {ras_n, lcas_n, ucas_n}, 7);
        check(!ready && !bus_req, "R1 ready/req low", {ready, bus_req}, 0);

        for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
        check(ready, "R2 ready after init", ready, 1);
        check(n_cbr == NINIT, "R2 init burst count", n_cbr, NINIT);
        check(first_cas >= PWRUP, "R1 power-up pause", first_cas, PWRUP);

        // R5 periodic refresh while idle
        base = n_cbr;
        push_expect(K_CBR, 5);
        wait_cyc(5 * IVL + 100);
        check(n_cbr - base == 5, "R5 refreshes per window", n_cbr - base, 5);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        // R6 defer while busy
        ctrl_idle = 1'b0;
        base = n_cbr;
        wait_cyc(3 * IVL);
        check(!bus_req && !urgent, "R6 no request while busy", {bus_req, urgent}, 0);
        check(n_cbr == base, "R6 no refresh while busy", n_cbr - base, 0);

        // R7 urgent burst
        push_expect(K_CBR, MAXP);
        base = b2b;
        for (int i = 0; i < 600 && !bus_req; i++) @(negedge clk);
        check(urgent == 1'b1, "R7 urgent with request", urgent, 1);
        check(bus_req == 1'b1, "R7 request while busy", bus_req, 1);
        wait_cyc(MAXP * (CSR + RASC + RP) + 10);
        check(n_cbr - 5 - NINIT == MAXP, "R7 queued issued", n_cbr - 5 - NINIT, MAXP);
        check(b2b - base == MAXP - 1, "R4 back-to-back gaps", b2b - base, MAXP - 1);
        check(!urgent && !bus_req, "R7 urgent cleared", {urgent, bus_req}, 0);

        // R9 self-refresh entry
        ctrl_idle = 1'b1;
        push_expect(K_SR, 1);
        sr_req = 1'b1;
        for (int i = 0; i < 500 && !sr_active; i++) @(negedge clk);
        check(sr_active, "R9 sr_active rises", sr_active, 1);
        check(ras_c >= SRH, "R9 hold before active", ras_c, SRH);
        wait_cyc(20);
        check(!ras_n && !lcas_n && sr_active, "R9 held in self-refresh", {ras_n, lcas_n}, 0);

        // R10 exit, then R11 reinit
        sr_req = 1'b0;
        wait_cyc(2);
        check(ras_n && !sr_active, "R10 exit raises RAS", {ras_n, sr_active}, 2);
        push_expect(K_CBR, NINIT);
        base = n_cbr;
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        wait_cyc(RPS + 4);
        check(!ready, "R11 ready dropped", ready, 0);
        for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
        check(ready, "R11 ready again", ready, 1);
        check(n_cbr - base == NINIT, "R11 reinit burst count", n_cbr - base, NINIT);
        check(n_sr == 1, "R9 one self-refresh seen", n_sr, 1);

        wait_cyc(20);
        check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
        check(mism == 0, "R12 byte strobes equal", mism, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule